// File: doc/BRIEF.md
# Memory Tester Error Capture Buffer

This block sits next to the data comparator of a memory tester. Each cycle in which the comparator reports a mismatch, the block stores one error record in on-chip storage in that same cycle. The record is the failing address joined to the mask of failing data bits. The capture side has no ready signal and never pushes back on the test stream.

The storage is split into two equal halves that take turns. New records fill one half. A half that is full, or that the host closes early with a flush pulse, is sealed. A sealed half is streamed out in capture order over a valid/ready port toward a larger backing memory, and is then emptied for reuse. Meanwhile the other half keeps taking records. Only when both halves are sealed does an arriving record get discarded. A discarded record raises a sticky overflow flag and is counted. A running total of all stored records is always visible on the ports.

Top module: `err_capture`

## Requirements
- R1: A stored record is 144 bits wide: the 32-bit failing address occupies bits 143:112 and the 112-bit failing-bit mask occupies bits 111:0.
- R2: A record is taken on every clock edge where `err_valid` is high and the active half has room. Back-to-back errors on consecutive cycles are all stored, with no stall signal on the capture side.
- R3: Each half holds 1024 records. The edge that writes the 1024th record seals the half. The sealed half is then drained with `drain_count` equal to 1024, in exactly the order the records were captured.
- R4: While one half drains, records keep going into the other half. When the drain rate keeps up, nothing is dropped.
- R5: While `drain_valid` is high and `drain_ready` is low, `drain_valid`, `drain_data` and `drain_count` hold their values.
- R6: An error arriving while both halves are sealed is not stored. It sets the sticky `overflow` flag and adds one to `drop_count`, which saturates at its maximum. Neither the flag nor the counter changes on later drains.
- R7: A `flush` pulse seals a partly filled active half. It then drains with `drain_count` equal to the number of records it holds, and `drain_last` is high on the final beat only. A record presented in the same cycle as the flush is included. A flush while the active half is empty has no effect.
- R8: `total_count` rises by one on the edge after each stored record and does not change for dropped records or idle cycles.
- R9: After reset, `drain_valid`, `overflow`, `total_count` and `drop_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Comparator reports a mismatch this cycle |
| err_addr | input | 32 | Failing address |
| err_mask | input | 112 | Failing data-bit mask |
| flush | input | 1 | Seal the active half if it holds records |
| drain_valid | output | 1 | A sealed half is presenting a record |
| drain_ready | input | 1 | Backing memory accepts the record |
| drain_data | output | 144 | Record being drained |
| drain_last | output | 1 | Final record of the current half |
| drain_count | output | 11 | Number of records in the half being drained |
| total_count | output | 32 | Records stored since reset |
| overflow | output | 1 | Sticky: a record was dropped |
| drop_count | output | 16 | Dropped records, saturating |

## Verification
Capture effects appear one edge after the cycle presenting the error. `total_count`, `overflow` and `drop_count` are therefore read at the falling edge after the capture edge. A sealed half shows `drain_valid` from the edge that wrote its last record or took the flush. A transfer counts when the falling-edge monitor sees valid and ready together, because inputs only change just after a rising edge. The monitor compares each such beat against a queue of the records sent in order. At `drain_last` it compares the beats it counted with `drain_count`.

// File: rtl/err_capture.sv
module err_capture #(
  parameter int AW         = 32,
  parameter int DW         = 112,
  parameter int HALF_DEPTH = 1024,
  parameter int TW         = 32,
  parameter int PW         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [AW-1:0]    err_addr,
  input  logic [DW-1:0]    err_mask,
  input  logic             flush,
  output logic             drain_valid,
  input  logic             drain_ready,
  output logic [AW+DW-1:0] drain_data,
  output logic             drain_last,
  output logic [$clog2(HALF_DEPTH):0] drain_count,
  output logic [TW-1:0]    total_count,
  output logic             overflow,
  output logic [PW-1:0]    drop_count
);
  localparam int EW = AW + DW;
  localparam int IW = $clog2(HALF_DEPTH);
  localparam int NW = IW + 1;

  logic [EW-1:0] mem [0:2*HALF_DEPTH-1];
  logic [NW-1:0] cnt [2];
  logic [1:0]    sealed;
  logic          wr_sel, rd_sel;
  logic [IW-1:0] rd_idx;

  wire           cap_ok   = err_valid && !sealed[wr_sel];
  wire           drop     = err_valid &&  sealed[wr_sel];
  wire [NW-1:0]  cur      = cnt[wr_sel];
  wire [NW-1:0]  nxt      = cur + NW'(cap_ok);
  wire           seal_now = !sealed[wr_sel] &&
                            ((nxt == NW'(HALF_DEPTH)) || (flush && nxt != '0));
  wire           pop      = drain_valid && drain_ready;

  assign drain_valid = sealed[rd_sel];
  assign drain_count = cnt[rd_sel];
  assign drain_data  = mem[{rd_sel, rd_idx}];
  assign drain_last  = drain_valid && ({1'b0, rd_idx} == cnt[rd_sel] - NW'(1));

  always_ff @(posedge clk)
    if (cap_ok) mem[{wr_sel, cur[IW-1:0]}] <= {err_addr, err_mask};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt[0]      <= '0;
      cnt[1]      <= '0;
      sealed      <= '0;
      wr_sel      <= 1'b0;
      rd_sel      <= 1'b0;
      rd_idx      <= '0;
      total_count <= '0;
      overflow    <= 1'b0;
      drop_count  <= '0;
    end else begin
      if (pop) begin
        if (drain_last) begin
          sealed[rd_sel] <= 1'b0;
          cnt[rd_sel]    <= '0;
          rd_idx         <= '0;
          rd_sel         <= ~rd_sel;
        end else begin
          rd_idx <= rd_idx + IW'(1);
        end
      end
      if (!sealed[wr_sel]) begin
        cnt[wr_sel] <= nxt;
        if (seal_now) begin
          sealed[wr_sel] <= 1'b1;
          wr_sel         <= ~wr_sel;
        end
      end
      if (cap_ok) total_count <= total_count + TW'(1);
      if (drop) begin
        overflow <= 1'b1;
        if (drop_count != '1) drop_count <= drop_count + PW'(1);
      end
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid && !drain_ready |=> drain_valid && $stable(drain_data) && $stable(drain_count));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R6
  drop_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !(sealed[0] && sealed[1]) |=> total_count == $past(total_count) + TW'(1));

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> drain_count != '0 && drain_count <= NW'(HALF_DEPTH));

  // R8
  total_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(total_count));
endmodule

// File: tb/sim_err_capture.sv
module sim_err_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic err_valid = 1'b0, flush = 1'b0, drain_ready = 1'b0;
  logic [31:0] err_addr = '0;
  logic [111:0] err_mask = '0;
  logic drain_valid, drain_last, overflow;
  logic [143:0] drain_data;
  logic [10:0] drain_count;
  logic [31:0] total_count;
  logic [15:0] drop_count;

  always #4 clk = ~clk;

  err_capture u0 (.clk, .rst_n, .err_valid, .err_addr, .err_mask, .flush,
    .drain_valid, .drain_ready, .drain_data, .drain_last, .drain_count,
    .total_count, .overflow, .drop_count);

  int checks = 0, fails = 0;
  logic [143:0] q[$];
  int beats = 0, last_batch = 0, batches = 0, sent = 0;
  bit expect_full = 0;
  int ready_mode = 0;

  function automatic logic [143:0] pack_entry(logic [31:0] a, logic [111:0] m);
    return {a, m};
  endfunction

  function automatic logic [111:0] rnd_mask();
    return {$urandom, $urandom, $urandom, 16'($urandom)};
  endfunction

  task automatic chk(bit ok, string req, logic [143:0] act, logic [143:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    drain_ready <= (ready_mode == 1) || (ready_mode == 2 && $urandom % 2 == 1);
  end

  // drain monitor: R1 R3 R7
  always @(negedge clk) begin
    if (rst_n && drain_valid && drain_ready) begin
      if (q.size() == 0) chk(0, "R3 unexpected beat", drain_data, '0);
      else begin
        logic [143:0] e;
        e = q.pop_front();
        chk(drain_data == e, "R1/R3 record order", drain_data, e);
      end
      beats++;
      if (drain_last) begin
        chk(drain_count == 11'(beats), "R7 drain_count vs beats", 144'(drain_count), 144'(beats));
        if (expect_full) chk(beats == 1024, "R3 full half size", 144'(beats), 144'd1024);
        last_batch = beats;
        batches++;
        beats = 0;
      end
    end
  end

  task automatic send(logic [31:0] a, logic [111:0] m, bit keep, bit fl);
    err_valid = 1'b1; err_addr = a; err_mask = m; flush = fl;
    if (keep) begin q.push_back(pack_entry(a, m)); sent++; end
    @(posedge clk); #1;
    err_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 20000 && q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(!drain_valid, "R9 drain_valid", 144'(drain_valid), 0);
    chk(!overflow, "R9 overflow", 144'(overflow), 0);
    chk(total_count == 0, "R9 total_count", 144'(total_count), 0);
    chk(drop_count == 0, "R9 drop_count", 144'(drop_count), 0);

    // R7 flush of empty half is ignored
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!drain_valid, "R7 empty flush", 144'(drain_valid), 0);
    end

    // R7 partial half, record in flush cycle included
    ready_mode = 1; expect_full = 0;
    @(posedge clk); #1;
    send(32'h0000_0010, 112'h1, 1, 0);
    send(32'h0000_0011, 112'h2, 1, 0);
    send(32'hFFFF_FFFF, {112{1'b1}}, 1, 1);
    wait_empty();
    chk(last_batch == 3, "R7 flushed batch size", 144'(last_batch), 144'd3);
    chk(total_count == 3, "R8 total after flush", 144'(total_count), 144'd3);

    // R2 R6 both halves full, back-to-back errors
    ready_mode = 0; expect_full = 1;
    repeat (2) @(posedge clk); #1;
    for (int i = 0; i < 2048; i++) send(32'(i) ^ 32'hA5A5_0000, rnd_mask(), 1, 0);
    for (int i = 0; i < 5; i++) send(32'hDEAD_0000 + 32'(i), rnd_mask(), 0, 0);
    @(negedge clk);
    chk(overflow, "R6 overflow set", 144'(overflow), 1);
    chk(drop_count == 5, "R6 drop_count", 144'(drop_count), 144'd5);
    chk(total_count == 2051, "R2/R8 total_count", 144'(total_count), 144'd2051);
    chk(drain_valid && drain_count == 1024, "R3 sealed count", 144'(drain_count), 144'd1024);
    // R5 held while not ready
    begin
      logic [143:0] d0;
      d0 = drain_data;
      repeat (3) @(negedge clk);
      chk(drain_data == d0 && drain_valid, "R5 hold", drain_data, d0);
    end
    ready_mode = 1;
    wait_empty();
    chk(batches == 3, "R3 batch count", 144'(batches), 144'd3);
    chk(overflow && drop_count == 5, "R6 sticky after drain", 144'(drop_count), 144'd5);

    // R4 random traffic with random drain backpressure
    ready_mode = 2;
    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 10 < 3) send($urandom, rnd_mask(), 1, 0);
      else begin @(posedge clk); #1; end
    end
    for (int i = 0; i < 20000 && drain_valid; i++) @(negedge clk);
    expect_full = 0; ready_mode = 1;
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    wait_empty();
    chk(q.size() == 0, "R4 all drained", 144'(q.size()), 0);
    chk(drop_count == 5, "R4 no new drops", 144'(drop_count), 144'd5);
    chk(total_count == 32'(sent), "R8 total vs sent", 144'(total_count), 144'(sent));
    chk(!drain_valid, "R7 idle after drain", 144'(drain_valid), 0);
    summary();
  end
endmodule